// File: doc/BRIEF.md
# Frequency Sweep Phase Generator

This block produces the phase word for a sine lookup table and for the reference of a single-bin DFT. It sweeps linearly through a set of excitation frequencies. The frequency code is the target frequency scaled by 2^27 over one quarter of the master clock. A 27-bit phase accumulator adds this code once every `DIV` master clock cycles. Software loads a start code, a step code, a step count and a settling count, then drives the sweep with commands.

Before every measurement the excitation runs for a programmed number of whole output periods. A period is one wrap of the accumulator. After that, a one-cycle strobe tells the measurement logic to begin. The measurement logic reports back with `meas_done`. The sequencer then waits for either an advance to the next frequency or a repeat at the present one. A done flag rises once the measurement at the final step has finished. The last frequency is the start code plus step code times step count.

Standby and power-down both stop the excitation and hold the phase at zero. Standby keeps the present frequency code. Power-down clears it.

Top module: `sweep_phase_gen`

## Requirements
- R1: While `rst` is high and after it falls, `phase_o`, `freq_o`, `step_idx_o`, `active_o`, `settle_done_o` and `sweep_done_o` are all zero.
- R2: While active, `phase_o` changes once every `DIV` clock cycles, and each change adds `freq_o` modulo 2^PHASE_W.
- R3: The initialize command (`cmd_op` = 1) latches all four programming inputs, loads `freq_o` with the start code, zeroes `step_idx_o` and `phase_o`, and sets `active_o`.
- R4: The start command (`cmd_op` = 2), accepted only just after initialize, raises `settle_done_o` once the accumulator has wrapped exactly `settle_count` times after the command. A count of zero gives the strobe with no wrap.
- R5: `settle_done_o` is high for a single cycle per settling wait.
- R6: The increment command (`cmd_op` = 3), accepted after a measurement that is not the final one, adds the step code to `freq_o` modulo 2^FREQ_W, raises `step_idx_o` by one, and starts a settling wait.
- R7: The repeat command (`cmd_op` = 4), accepted after any finished measurement, starts a settling wait and leaves `freq_o` and `step_idx_o` unchanged.
- R8: `sweep_done_o` rises when `meas_done` ends the measurement at step index equal to the step count. `freq_o` then equals start + step × count.
- R9: An increment command while `sweep_done_o` is high is ignored: `freq_o`, `step_idx_o` and `sweep_done_o` keep their values.
- R10: The power-down command (`cmd_op` = 5) clears `active_o`, `freq_o`, `step_idx_o`, `phase_o` and `sweep_done_o`. Whenever `active_o` is low, `phase_o` is zero.
- R11: The standby command (`cmd_op` = 6) clears `active_o` and holds `phase_o` at zero, while `freq_o` keeps its value.
- R12: A start command outside the state just after initialize, and a `meas_done` pulse while no measurement is pending, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code (1 init, 2 start, 3 increment, 4 repeat, 5 power-down, 6 standby) |
| start_code | input | FREQ_W | Start frequency code |
| step_code | input | FREQ_W | Frequency increment code |
| step_count | input | CNT_W | Number of increments in the sweep |
| settle_count | input | SETTLE_W | Output periods to wait before each measurement |
| meas_done | input | 1 | Measurement at the present frequency finished |
| phase_o | output | PHASE_W | Phase accumulator value |
| freq_o | output | FREQ_W | Present frequency code |
| step_idx_o | output | CNT_W | Present step index |
| active_o | output | 1 | Excitation running |
| settle_done_o | output | 1 | Settling finished, start measurement (one cycle) |
| sweep_done_o | output | 1 | Final step measured |

## Verification
The bench builds the block with a 10-bit frequency code, a 12-bit accumulator, 4-bit step and settling counts, and a divider of 4. With these sizes an output period is only a few dozen to a few thousand clocks. That brings several complete settling waits, a full sweep with a repeat and an ignored increment, and a frequency code that wraps past its top within a short run. Counting accumulator wraps at the phase port, independently of the design, pins down the settling length. This includes the zero-count case.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_INIT   = 3'd1,
    OP_START  = 3'd2,
    OP_INCR   = 3'd3,
    OP_REPEAT = 3'd4,
    OP_PWRDN  = 3'd5,
    OP_STBY   = 3'd6
  } sweep_op_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_STBY,
    ST_EXCITE,
    ST_SETTLE,
    ST_MEAS,
    ST_HOLD,
    ST_DONE
  } sweep_state_e;

endpackage

// File: rtl/sweep_tick.sv
module sweep_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sweep_phase_acc.sv
module sweep_phase_acc #(
  parameter int FREQ_W  = 24,
  parameter int PHASE_W = 27
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               en,
  input  logic [FREQ_W-1:0]  freq,
  output logic [PHASE_W-1:0] phase,
  output logic               wrap
);
  localparam int SUM_W = PHASE_W + 1;

  logic [SUM_W-1:0] sum;
  assign sum = {1'b0, phase} + SUM_W'(freq);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase <= '0;
      wrap  <= 1'b0;
    end else if (en) begin
      phase <= sum[PHASE_W-1:0];
      wrap  <= sum[PHASE_W];
    end else begin
      wrap  <= 1'b0;
    end
  end
endmodule

// File: rtl/sweep_settle.sv
module sweep_settle #(
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                abort,
  input  logic                arm,
  input  logic [SETTLE_W-1:0] target,
  input  logic                wrap,
  output logic                hit
);
  logic [SETTLE_W-1:0] cnt_q;
  logic                armed_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      hit     <= 1'b0;
    end else if (arm) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      hit     <= 1'b0;
    end else if (armed_q) begin
      if (cnt_q == target) begin
        hit     <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        hit <= 1'b0;
        if (wrap) cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      hit <= 1'b0;
    end
  end
endmodule

// File: rtl/sweep_phase_gen.sv
module sweep_phase_gen
  import sweep_pkg::*;
#(
  parameter int FREQ_W   = 24,
  parameter int PHASE_W  = 27,
  parameter int CNT_W    = 9,
  parameter int SETTLE_W = 16,
  parameter int DIV      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [FREQ_W-1:0]   start_code,
  input  logic [FREQ_W-1:0]   step_code,
  input  logic [CNT_W-1:0]    step_count,
  input  logic [SETTLE_W-1:0] settle_count,
  input  logic                meas_done,
  output logic [PHASE_W-1:0]  phase_o,
  output logic [FREQ_W-1:0]   freq_o,
  output logic [CNT_W-1:0]    step_idx_o,
  output logic                active_o,
  output logic                settle_done_o,
  output logic                sweep_done_o
);
  sweep_op_e     op;
  sweep_state_e  state_q, state_n;
  logic [FREQ_W-1:0]   freq_q, freq_n, step_q;
  logic [CNT_W-1:0]    idx_q, idx_n, count_q;
  logic [SETTLE_W-1:0] settle_q;
  logic tick, wrap, hit;
  logic acc_clear, arm, abort, load, taken, strobe_n;

  assign op = sweep_op_e'(cmd_op);

  sweep_tick #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  sweep_phase_acc #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .clear(acc_clear),
    .en   (tick && active_o),
    .freq (freq_q),
    .phase(phase_o),
    .wrap (wrap)
  );

  sweep_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk   (clk),
    .rst   (rst),
    .abort (abort),
    .arm   (arm),
    .target(settle_q),
    .wrap  (wrap),
    .hit   (hit)
  );

  always_comb begin
    state_n   = state_q;
    freq_n    = freq_q;
    idx_n     = idx_q;
    acc_clear = 1'b0;
    arm       = 1'b0;
    abort     = 1'b0;
    load      = 1'b0;
    taken     = 1'b0;
    strobe_n  = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_INIT: begin
          state_n = ST_EXCITE; freq_n = start_code; idx_n = '0;
          acc_clear = 1'b1; abort = 1'b1; load = 1'b1; taken = 1'b1;
        end
        OP_START: if (state_q == ST_EXCITE) begin
          state_n = ST_SETTLE; arm = 1'b1; taken = 1'b1;
        end
        OP_INCR: if (state_q == ST_HOLD) begin
          state_n = ST_SETTLE; freq_n = freq_q + step_q;
          idx_n = idx_q + 1'b1; arm = 1'b1; taken = 1'b1;
        end
        OP_REPEAT: if (state_q == ST_HOLD || state_q == ST_DONE) begin
          state_n = ST_SETTLE; arm = 1'b1; taken = 1'b1;
        end
        OP_PWRDN: begin
          state_n = ST_OFF; freq_n = '0; idx_n = '0;
          acc_clear = 1'b1; abort = 1'b1; taken = 1'b1;
        end
        OP_STBY: begin
          state_n = ST_STBY; acc_clear = 1'b1; abort = 1'b1; taken = 1'b1;
        end
        default: ;
      endcase
    end
    if (!taken) begin
      if (state_q == ST_SETTLE && hit) begin
        state_n  = ST_MEAS;
        strobe_n = 1'b1;
      end else if (state_q == ST_MEAS && meas_done) begin
        state_n = (idx_q == count_q) ? ST_DONE : ST_HOLD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_OFF;
      freq_q        <= '0;
      idx_q         <= '0;
      step_q        <= '0;
      count_q       <= '0;
      settle_q      <= '0;
      active_o      <= 1'b0;
      settle_done_o <= 1'b0;
      sweep_done_o  <= 1'b0;
    end else begin
      state_q       <= state_n;
      freq_q        <= freq_n;
      idx_q         <= idx_n;
      active_o      <= (state_n != ST_OFF) && (state_n != ST_STBY);
      settle_done_o <= strobe_n;
      sweep_done_o  <= (state_n == ST_DONE);
      if (load) begin
        step_q   <= step_code;
        count_q  <= step_count;
        settle_q <= settle_count;
      end
    end
  end

  assign freq_o     = freq_q;
  assign step_idx_o = idx_q;
endmodule

// File: rtl/sweep_phase_gen_chk.sv
module sweep_phase_gen_chk #(
  parameter int FREQ_W  = 24,
  parameter int PHASE_W = 27,
  parameter int CNT_W   = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [2:0]         cmd_op,
  input logic [PHASE_W-1:0] phase_o,
  input logic [FREQ_W-1:0]  freq_o,
  input logic [CNT_W-1:0]   step_idx_o,
  input logic [CNT_W-1:0]   count_q,
  input logic               active_o,
  input logic               settle_done_o,
  input logic               sweep_done_o
);
  // R2: every phase change while running adds the frequency code
  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    (active_o && $past(active_o) && !$past(cmd_valid) && phase_o != $past(phase_o))
      |-> phase_o == ($past(phase_o) + PHASE_W'($past(freq_o))));

  // R10: a stopped output holds phase zero
  p_idle_phase_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> phase_o == '0);

  // R5: settling strobe lasts one cycle
  p_settle_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    settle_done_o |=> !settle_done_o);

  // R8: done only at the final step index
  p_done_index_r8: assert property (@(posedge clk) disable iff (rst)
    sweep_done_o |-> step_idx_o == count_q);

  // R9: increment after completion changes nothing
  p_incr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (sweep_done_o && cmd_valid && cmd_op == 3'd3)
      |=> ($stable(freq_o) && $stable(step_idx_o) && sweep_done_o));

  // R7: repeat never moves the frequency
  p_repeat_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd4) |=> ($stable(freq_o) && $stable(step_idx_o)));

  // R11: standby keeps the code and stops the output
  p_stby_keep_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd6) |=> ($stable(freq_o) && !active_o));
endmodule

bind sweep_phase_gen sweep_phase_gen_chk #(
  .FREQ_W (FREQ_W),
  .PHASE_W(PHASE_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .phase_o      (phase_o),
  .freq_o       (freq_o),
  .step_idx_o   (step_idx_o),
  .count_q      (count_q),
  .active_o     (active_o),
  .settle_done_o(settle_done_o),
  .sweep_done_o (sweep_done_o)
);

// File: tb/tb_sweep_phase_gen.sv
module tb_sweep_phase_gen;
  localparam int FREQ_W = 10, PHASE_W = 12, CNT_W = 4, SETTLE_W = 4, DIV = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [FREQ_W-1:0] start_code = '0, step_code = '0;
  logic [CNT_W-1:0] step_count = '0;
  logic [SETTLE_W-1:0] settle_count = '0;
  logic meas_done = 1'b0;
  logic [PHASE_W-1:0] phase_o;
  logic [FREQ_W-1:0] freq_o;
  logic [CNT_W-1:0] step_idx_o;
  logic active_o, settle_done_o, sweep_done_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [PHASE_W-1:0] prev_ph;

  always #2 clk = ~clk;

  sweep_phase_gen #(.FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .CNT_W(CNT_W),
                    .SETTLE_W(SETTLE_W), .DIV(DIV)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .start_code(start_code), .step_code(step_code), .step_count(step_count),
    .settle_count(settle_count), .meas_done(meas_done), .phase_o(phase_o),
    .freq_o(freq_o), .step_idx_o(step_idx_o), .active_o(active_o),
    .settle_done_o(settle_done_o), .sweep_done_o(sweep_done_o));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; prev_ph = phase_o;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic do_init(input int s, input int st, input int c, input int w);
    start_code = FREQ_W'(s); step_code = FREQ_W'(st);
    step_count = CNT_W'(c); settle_count = SETTLE_W'(w);
    issue(3'd1);
    check("R3 freq after init", int'(freq_o), s & 1023);
    check("R3 index after init", int'(step_idx_o), 0);
    check("R3 active after init", int'(active_o), 1);
    check("R3 phase cleared", int'(phase_o), 0);
  endtask

  // Counts wraps seen at the phase port up to three edges before the strobe.
  task automatic wait_settle(input int exp, input string tag);
    int drops = 0; bit d0 = 0, d1 = 0, d2 = 0, got = 0, dr;
    for (int i = 0; i < 20000; i++) begin
      dr = (phase_o < prev_ph); prev_ph = phase_o;
      d2 = d1; d1 = d0; d0 = dr; drops += int'(dr);
      if (settle_done_o) begin got = 1; break; end
      @(negedge clk);
    end
    check({tag, " strobe seen"}, int'(got), 1);
    check({tag, " wraps before strobe"}, drops - int'(d0) - int'(d1) - int'(d2), exp);
    @(negedge clk);
    check("R5 strobe one cycle", int'(settle_done_o), 0);
  endtask

  task automatic pulse_meas;
    @(negedge clk); meas_done = 1'b1;
    @(negedge clk); meas_done = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 phase in reset", int'(phase_o), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 phase", int'(phase_o), 0);
    check("R1 freq", int'(freq_o), 0);
    check("R1 index", int'(step_idx_o), 0);
    check("R1 active", int'(active_o), 0);
    check("R1 strobe", int'(settle_done_o), 0);
    check("R1 done", int'(sweep_done_o), 0);
  endtask

  task automatic t_phase_rate;
    logic [PHASE_W-1:0] p0, p1; int gap;
    do_init(100, 37, 3, 2);
    p0 = phase_o;
    while (phase_o == p0) @(negedge clk);
    p1 = phase_o; gap = 0;
    while (phase_o == p1) begin @(negedge clk); gap++; end
    check("R2 clocks per step", gap, DIV);
    check("R2 phase delta", int'(PHASE_W'(phase_o - p1)), 100);
  endtask

  task automatic t_full_sweep;
    issue(3'd2); wait_settle(2, "R4 start");
    pulse_meas;
    check("R8 not done at step 0", int'(sweep_done_o), 0);
    pulse_meas;
    check("R12 stray meas_done", int'(sweep_done_o), 0);
    issue(3'd3);
    check("R6 freq after incr", int'(freq_o), 137);
    check("R6 index after incr", int'(step_idx_o), 1);
    wait_settle(2, "R6 settle"); pulse_meas;
    issue(3'd4);
    check("R7 freq after repeat", int'(freq_o), 137);
    check("R7 index after repeat", int'(step_idx_o), 1);
    wait_settle(2, "R7 settle"); pulse_meas;
    issue(3'd3); wait_settle(2, "R6 settle 2"); pulse_meas;
    issue(3'd3); wait_settle(2, "R6 settle 3");
    check("R8 not done before meas", int'(sweep_done_o), 0);
    pulse_meas;
    check("R8 done", int'(sweep_done_o), 1);
    check("R8 last freq", int'(freq_o), 100 + 37 * 3);
    issue(3'd3);
    check("R9 freq kept", int'(freq_o), 211);
    check("R9 index kept", int'(step_idx_o), 3);
    check("R9 done kept", int'(sweep_done_o), 1);
    issue(3'd4); wait_settle(2, "R7 repeat at end"); pulse_meas;
    check("R7 done again", int'(sweep_done_o), 1);
  endtask

  task automatic t_stray_start;
    int seen = 0;
    issue(3'd2);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); seen += int'(settle_done_o);
    end
    check("R12 start ignored", seen, 0);
    check("R12 done unchanged", int'(sweep_done_o), 1);
  endtask

  task automatic t_zero_settle;
    do_init(500, 1, 1, 0);
    issue(3'd2); wait_settle(0, "R4 zero count");
  endtask

  task automatic t_freq_wrap;
    pulse_meas;
    do_init(1000, 30, 1, 1);
    issue(3'd2); wait_settle(1, "R4 one period"); pulse_meas;
    issue(3'd3);
    check("R6 code wraps", int'(freq_o), (1000 + 30) % 1024);
    wait_settle(1, "R6 slow settle"); pulse_meas;
    check("R8 done single step", int'(sweep_done_o), 1);
  endtask

  task automatic t_stby_pwrdn;
    int moved = 0;
    issue(3'd6);
    check("R11 active", int'(active_o), 0);
    check("R11 freq kept", int'(freq_o), 6);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); moved += int'(phase_o != 0);
    end
    check("R11 phase held", moved, 0);
    issue(3'd5);
    check("R10 active", int'(active_o), 0);
    check("R10 freq", int'(freq_o), 0);
    check("R10 index", int'(step_idx_o), 0);
    check("R10 phase", int'(phase_o), 0);
    check("R10 done", int'(sweep_done_o), 0);
  endtask

  initial begin
    t_reset;
    t_phase_rate;
    t_full_sweep;
    t_stray_start;
    t_zero_settle;
    t_freq_wrap;
    t_stby_pwrdn;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule